// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-access requester and the memory windows of a root port. Each request names a bus, a device, a function, a register offset and a direction. The block first decides whether such a device can exist at all. A request for a device that cannot exist never reaches memory: a read completes with all ones, and a write is refused with an error flag.

For a device that can exist, the block reprograms an outbound translation window through a small setup port. It always writes the transaction type. It writes the remote target only when the access leaves the root port. It then issues a single word access on a request/response memory port. Bus 0 is served from the root port's own register window. Every other bus is served through the outbound configuration window.

A read that faults, or that gets no answer within a bounded number of cycles, also returns all ones and raises no error. Only one request is in flight at a time. A busy indication holds off any further requests until the current one has been answered.

Top module: `cfg_xlate`

## Requirements
- R1: Every valid access starts with a type write on the setup port (`setup_sel`=0). The code is 0x4 for buses 0 and 1 and 0x5 for buses 2 to 255.
- R2: A valid access to bus 0 writes no target (no setup beat with `setup_sel`=1). It then accesses memory with `mem_remote`=0 at `LOCAL_BASE` plus the aligned offset.
- R3: A valid access to any bus other than 0 writes a target (`setup_sel`=1) with bus in bits 31:24, device in bits 23:19, function in bits 18:16 and zeros in bits 15:0. It then accesses memory with `mem_remote`=1 at `REMOTE_BASE` plus the aligned offset.
- R4: The offset added to the window base has its two low bits cleared, so `mem_addr[1:0]` is always 0.
- R5: A device above 1 on bus 0, or a device above 0 on bus 1, is invalid. Such a request produces no setup beat and no memory access.
- R6: A read of an invalid device responds with data 0xFFFFFFFF and `rsp_err`=0. A write to an invalid device responds with `rsp_err`=1.
- R7: A valid read whose memory answer carries `mem_fault`, or that gets no `mem_done` within `TIMEOUT` cycles, responds with 0xFFFFFFFF and `rsp_err`=0. A valid write always responds with `rsp_err`=0.
- R8: The setup beats and the memory access happen in this order: type, then target, then access. `req_ready` is low from the cycle after acceptance through the response cycle. A request held during that time is not taken, and each accepted request gives exactly one `rsp_valid` pulse.
- R9: A valid read returns `mem_rdata` unchanged. A valid write presents `req_wdata` on `mem_wdata` with `mem_write`=1. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | OFF_W | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Request refused |
| setup_valid | output | 1 | Window setup beat |
| setup_sel | output | 1 | 0 = type register, 1 = target register |
| setup_data | output | 32 | Value written to the selected register |
| mem_valid | output | 1 | Memory access held until done or timeout |
| mem_write | output | 1 | Access direction |
| mem_remote | output | 1 | 0 = root register window, 1 = outbound window |
| mem_addr | output | ADDR_W | Word-aligned local address |
| mem_wdata | output | 32 | Write data |
| mem_done | input | 1 | Memory access finished |
| mem_fault | input | 1 | Access faulted (valid with mem_done) |
| mem_rdata | input | 32 | Read data (valid with mem_done) |

## Verification
The assertions assume that the memory side raises `mem_done` only while `mem_valid` is high, for a single cycle. They also assume that the setup port takes each beat in the cycle it is shown. The checker keeps its own copy of the request fields taken at acceptance. It therefore assumes the requester's fields are meaningful whenever `req_valid` and `req_ready` are both high. The bench's memory responder pulses `mem_done` once after a chosen latency, or never, to model a silent target. It drives requests only in the idle window, except in the one scenario that holds a request on purpose while the block is busy.

// File: rtl/cfg_xlate.sv
module cfg_xlate #(
  parameter int          OFF_W       = 12,
  parameter int          ADDR_W      = 32,
  parameter int          TIMEOUT     = 16,
  parameter logic [31:0] LOCAL_BASE  = 32'h01FF_C000,
  parameter logic [31:0] REMOTE_BASE = 32'h01F0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_fn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              setup_valid,
  output logic              setup_sel,
  output logic [31:0]       setup_data,
  output logic              mem_valid,
  output logic              mem_write,
  output logic              mem_remote,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_done,
  input  logic              mem_fault,
  input  logic [31:0]       mem_rdata
);
  localparam int          CNT_W   = $clog2(TIMEOUT + 1);
  localparam logic [2:0]  TYPE_NEAR = 3'h4;
  localparam logic [2:0]  TYPE_FAR  = 3'h5;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {S_IDLE, S_TYPE, S_TGT, S_ACC, S_RESP} st_t;

  st_t              st;
  logic             w_wr;
  logic [7:0]       w_bus;
  logic [4:0]       w_dev;
  logic [2:0]       w_fn;
  logic [OFF_W-1:0] w_off;
  logic [31:0]      w_wdata;
  logic [31:0]      r_data;
  logic             r_err;
  logic [CNT_W-1:0] wait_cnt;

  logic absent, expired;
  assign absent  = (req_bus == 8'd0 && req_dev > 5'd1) || (req_bus == 8'd1 && req_dev != 5'd0);
  assign expired = (wait_cnt == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      w_wr     <= 1'b0;
      w_bus    <= '0;
      w_dev    <= '0;
      w_fn     <= '0;
      w_off    <= '0;
      w_wdata  <= '0;
      r_data   <= '0;
      r_err    <= 1'b0;
      wait_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          w_wr    <= req_write;
          w_bus   <= req_bus;
          w_dev   <= req_dev;
          w_fn    <= req_fn;
          w_off   <= {req_off[OFF_W-1:2], 2'b00};
          w_wdata <= req_wdata;
          if (absent) begin
            r_data <= req_write ? 32'd0 : ALL_ONES;
            r_err  <= req_write;
            st     <= S_RESP;
          end else begin
            st <= S_TYPE;
          end
        end
        S_TYPE: begin
          wait_cnt <= '0;
          st       <= (w_bus != 8'd0) ? S_TGT : S_ACC;
        end
        S_TGT: st <= S_ACC;
        S_ACC: begin
          if (mem_done) begin
            r_data <= w_wr ? 32'd0 : (mem_fault ? ALL_ONES : mem_rdata);
            r_err  <= 1'b0;
            st     <= S_RESP;
          end else if (expired) begin
            r_data <= w_wr ? 32'd0 : ALL_ONES;
            r_err  <= 1'b0;
            st     <= S_RESP;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign rsp_valid   = (st == S_RESP);
  assign rsp_rdata   = r_data;
  assign rsp_err     = r_err;
  assign setup_valid = (st == S_TYPE) || (st == S_TGT);
  assign setup_sel   = (st == S_TGT);
  assign setup_data  = (st == S_TGT) ? {w_bus, w_dev, w_fn, 16'h0000}
                                     : {29'd0, (w_bus < 8'd2) ? TYPE_NEAR : TYPE_FAR};
  assign mem_valid   = (st == S_ACC);
  assign mem_write   = w_wr;
  assign mem_remote  = (w_bus != 8'd0);
  assign mem_addr    = ((w_bus != 8'd0) ? REMOTE_BASE[ADDR_W-1:0] : LOCAL_BASE[ADDR_W-1:0])
                       + {{(ADDR_W-OFF_W){1'b0}}, w_off};
  assign mem_wdata   = w_wdata;
endmodule

module cfg_xlate_chk #(
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [7:0]        req_bus,
  input logic [4:0]        req_dev,
  input logic [2:0]        req_fn,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              setup_valid,
  input logic              setup_sel,
  input logic [31:0]       setup_data,
  input logic              mem_valid,
  input logic              mem_remote,
  input logic [ADDR_W-1:0] mem_addr
);
  logic       c_wr;
  logic [7:0] c_bus;
  logic [4:0] c_dev;
  logic [2:0] c_fn;
  logic       c_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wr <= 1'b0; c_bus <= '0; c_dev <= '0; c_fn <= '0;
    end else if (req_valid && req_ready) begin
      c_wr <= req_write; c_bus <= req_bus; c_dev <= req_dev; c_fn <= req_fn;
    end
  end
  assign c_bad = (c_bus == 8'd0 && c_dev > 5'd1) || (c_bus == 8'd1 && c_dev != 5'd0);

  assert_type_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && !setup_sel |-> setup_data == ((c_bus < 8'd2) ? 32'h4 : 32'h5));
  assert_local_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_remote == (c_bus != 8'd0));
  assert_no_target_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && setup_sel |-> c_bus != 8'd0);
  assert_target_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && setup_sel |-> setup_data == {c_bus, c_dev, c_fn, 16'h0000});
  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  assert_filtered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || setup_valid) |-> !c_bad);
  assert_absent_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && c_bad |-> (rsp_err == c_wr) && (c_wr || rsp_rdata == 32'hFFFF_FFFF));
  assert_read_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !c_wr |-> !rsp_err);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_setup_before_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !$past(mem_valid) |-> $past(setup_valid));
  assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({setup_valid, mem_valid, rsp_valid, req_ready}));
endmodule

bind cfg_xlate cfg_xlate_chk #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .setup_valid(setup_valid), .setup_sel(setup_sel), .setup_data(setup_data),
  .mem_valid(mem_valid), .mem_remote(mem_remote), .mem_addr(mem_addr)
);

// File: tb/sim_cfg_xlate.sv
`timescale 1ns/1ps
module sim_cfg_xlate;
  localparam logic [31:0] LB = 32'h01FF_C000;
  localparam logic [31:0] RB = 32'h01F0_0000;
  localparam int TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [7:0] req_bus = 0;
  logic [4:0] req_dev = 0;
  logic [2:0] req_fn = 0;
  logic [11:0] req_off = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err, setup_valid, setup_sel;
  logic [31:0] rsp_rdata, setup_data, mem_wdata, mem_addr;
  logic mem_valid, mem_write, mem_remote;
  logic mem_done = 0, mem_fault = 0;
  logic [31:0] mem_rdata = 0;

  cfg_xlate #(.TIMEOUT(TMO), .LOCAL_BASE(LB), .REMOTE_BASE(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
    .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .setup_valid(setup_valid),
    .setup_sel(setup_sel), .setup_data(setup_data), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_remote(mem_remote), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_fault(mem_fault),
    .mem_rdata(mem_rdata));

  int checks = 0, errors = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory responder: mode 0 normal, 1 fault, 2 silent
  int m_mode = 0, m_lat = 2, m_cnt = 0;
  logic [31:0] m_data = 0;
  initial forever begin
    @(negedge clk);
    if (mem_valid && !mem_done) begin
      m_cnt++;
      if (m_cnt >= m_lat && m_mode != 2) begin
        mem_done = 1; mem_fault = (m_mode == 1); mem_rdata = m_data;
      end
    end else begin
      mem_done = 0; mem_fault = 0; m_cnt = 0;
    end
  end

  // observer of setup beats and memory accesses
  int seq = 0, n_type = 0, n_tgt = 0, n_mem = 0, n_rsp = 0;
  int type_seq = 0, tgt_seq = 0, mem_seq = 0;
  logic [31:0] type_v = 0, tgt_v = 0, maddr = 0, mwd = 0;
  logic mrem = 0, mwr = 0, mprev = 0;
  initial forever begin
    @(negedge clk);
    seq++;
    if (setup_valid && !setup_sel) begin n_type++; type_v = setup_data; type_seq = seq; end
    if (setup_valid && setup_sel)  begin n_tgt++;  tgt_v = setup_data;  tgt_seq = seq;  end
    if (mem_valid && !mprev) begin
      n_mem++; mem_seq = seq; maddr = mem_addr; mrem = mem_remote; mwr = mem_write; mwd = mem_wdata;
    end
    if (rsp_valid) n_rsp++;
    mprev = mem_valid;
  end

  logic [31:0] g_data; logic g_err; int g_lat;
  task automatic run(input logic wr, input logic [7:0] b, input logic [4:0] d,
                     input logic [2:0] f, input logic [11:0] o, input logic [31:0] wd);
    @(negedge clk);
    n_type = 0; n_tgt = 0; n_mem = 0; n_rsp = 0;
    req_valid = 1; req_write = wr; req_bus = b; req_dev = d; req_fn = f; req_off = o; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    g_lat = 1;
    while (!rsp_valid && g_lat < 200) begin @(negedge clk); g_lat++; end
    g_data = rsp_rdata; g_err = rsp_err;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8 reset req_ready", {31'd0, req_ready}, 1);
    chk("R8 reset rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R8 reset setup/mem idle", {30'd0, setup_valid, mem_valid}, 0);
  endtask

  task automatic t_local_read;
    m_mode = 0; m_lat = 2; m_data = 32'h1234_5678;
    run(0, 8'd0, 5'd1, 3'd2, 12'h10B, 0);
    chk("R1 bus0 type code", type_v, 32'h4);
    chk("R1 one type beat", n_type, 1);
    chk("R2 bus0 no target beat", n_tgt, 0);
    chk("R2 bus0 local window", {31'd0, mrem}, 0);
    chk("R4 bus0 aligned address", maddr, LB + 32'h108);
    chk("R9 read data", g_data, 32'h1234_5678);
    chk("R9 read no error", {31'd0, g_err}, 0);
  endtask

  task automatic t_remote_read;
    m_mode = 0; m_lat = 1; m_data = 32'hCAFE_0001;
    run(0, 8'd1, 5'd0, 3'd3, 12'h023, 0);
    chk("R1 bus1 type code", type_v, 32'h4);
    chk("R3 bus1 target", tgt_v, {8'd1, 5'd0, 3'd3, 16'h0});
    chk("R3 bus1 remote window", {31'd0, mrem}, 1);
    chk("R4 bus1 aligned address", maddr, RB + 32'h020);
    chk("R8 type before target", {31'd0, type_seq < tgt_seq}, 1);
    chk("R8 target before access", {31'd0, tgt_seq < mem_seq}, 1);
    chk("R9 remote read data", g_data, 32'hCAFE_0001);
  endtask

  task automatic t_type1_write;
    m_mode = 0; m_lat = 3;
    run(1, 8'd2, 5'd7, 3'd5, 12'h047, 32'hA5A5_5A5A);
    chk("R1 bus2 type code", type_v, 32'h5);
    chk("R3 bus2 target", tgt_v, {8'd2, 5'd7, 3'd5, 16'h0});
    chk("R4 bus2 aligned address", maddr, RB + 32'h044);
    chk("R9 write strobe", {31'd0, mwr}, 1);
    chk("R9 write data", mwd, 32'hA5A5_5A5A);
    chk("R9 write rsp data", g_data, 0);
    chk("R7 write no error", {31'd0, g_err}, 0);
    run(0, 8'd255, 5'd31, 3'd7, 12'hFFF, 0);
    chk("R1 bus255 type code", type_v, 32'h5);
    chk("R3 bus255 target", tgt_v, 32'hFFFF_0000);
    chk("R4 top offset aligned", maddr, RB + 32'hFFC);
  endtask

  task automatic t_filter;
    m_mode = 0; m_lat = 1; m_data = 32'h0;
    run(0, 8'd0, 5'd2, 3'd0, 12'h000, 0);
    chk("R5 bus0 dev2 no setup", n_type + n_tgt, 0);
    chk("R5 bus0 dev2 no access", n_mem, 0);
    chk("R6 absent read data", g_data, 32'hFFFF_FFFF);
    chk("R6 absent read no error", {31'd0, g_err}, 0);
    run(1, 8'd1, 5'd1, 3'd0, 12'h004, 32'h1);
    chk("R5 bus1 dev1 no access", n_mem, 0);
    chk("R6 absent write error", {31'd0, g_err}, 1);
    run(0, 8'd0, 5'd31, 3'd7, 12'h0, 0);
    chk("R6 bus0 dev31 all ones", g_data, 32'hFFFF_FFFF);
    run(0, 8'd2, 5'd31, 3'd0, 12'h0, 0);
    chk("R5 bus2 dev31 accessed", n_mem, 1);
    chk("R5 bus2 dev31 data", g_data, 32'h0);
  endtask

  task automatic t_fault;
    m_mode = 1; m_lat = 2; m_data = 32'h1111_2222;
    run(0, 8'd3, 5'd0, 3'd0, 12'h010, 0);
    chk("R7 faulted read data", g_data, 32'hFFFF_FFFF);
    chk("R7 faulted read no error", {31'd0, g_err}, 0);
    run(1, 8'd3, 5'd0, 3'd0, 12'h010, 32'h9);
    chk("R7 faulted write no error", {31'd0, g_err}, 0);
    m_mode = 2;
    run(0, 8'd0, 5'd0, 3'd0, 12'h008, 0);
    chk("R7 silent read data", g_data, 32'hFFFF_FFFF);
    chk("R7 silent read no error", {31'd0, g_err}, 0);
    chk("R7 silent read gave up", {31'd0, g_lat >= TMO && g_lat < 200}, 1);
    m_mode = 0;
  endtask

  task automatic t_busy;
    int hold;
    m_mode = 0; m_lat = 4; m_data = 32'h0BAD_F00D;
    @(negedge clk);
    n_type = 0; n_tgt = 0; n_mem = 0; n_rsp = 0;
    req_valid = 1; req_write = 0; req_bus = 8'd4; req_dev = 5'd1; req_fn = 3'd1; req_off = 12'h30;
    @(negedge clk);
    chk("R8 busy after accept", {31'd0, req_ready}, 0);
    req_bus = 8'd0; req_dev = 5'd0; req_off = 12'h0;
    hold = 0;
    while (!rsp_valid && hold < 200) begin @(negedge clk); hold++; end
    chk("R8 busy in response cycle", {31'd0, req_ready}, 0);
    chk("R8 first request served", rsp_rdata, 32'h0BAD_F00D);
    req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 single type beat", n_type, 1);
    chk("R8 held request not taken", n_rsp, 1);
    chk("R8 held request address", maddr, RB + 32'h30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_local_read;
    t_remote_read;
    t_type1_write;
    t_filter;
    t_fault;
    t_busy;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule